// File: doc/BRIEF.md
# Multiplexed Host Register Port

This block is a slave port for a local host. The host reads and writes a small bank of byte-wide configuration registers through one 8-bit bidirectional bus. The bus carries either an address or data. A data-select line chooses the target. When it is low, the access goes to an internal address register. When it is high, the access goes to the configuration register that the address register points at. An active-low chip select frames each access, and a write line gives its direction. The port drives the bus only while the host is reading.

The control inputs are not synchronous to the block clock. They pass through a two-flop synchronizer, together with the bus value. A write takes effect when the synchronized select returns high. The value written is the last bus value seen while the select was low. Reads use combinational paths, so the addressed byte appears on the pads while the select is low.

A control bit enables the port and is set at reset. Once software clears it, host accesses are ignored and the eight pads act as general-purpose outputs. An active-low interrupt request goes to the host. It is built from a flag register and a mask register.

Top module: `hrp_top`

## Requirements
- R1: After reset the address register holds 0x00, register 0 holds 0x01, registers 1 to 7 hold 0x00, `int_req_n` is high and `pad_oe` is 0x00.
- R2: A write is accepted when `cs_n` is low and `wr_sel` is high. It takes effect at the third rising clock edge after `cs_n` returns high, and `cs_n` must stay high across at least one rising edge. The value written is the bus value seen while selected, and later changes on the bus or the control lines have no effect on it.
- R3: With `dsel` low the access targets the address register. With `dsel` high it targets the register whose index is in the address register.
- R4: With `cs_n` low and `wr_sel` low, `pad_out` shows the address register (`dsel` low) or the addressed register (`dsel` high). A read changes no state.
- R5: While the port is enabled, all 8 bits of `pad_oe` are high exactly while `cs_n` is low and `wr_sel` is low. Otherwise all 8 bits are 0.
- R6: There are eight full 8-bit read/write registers. Index 0 is control, and bit 0 of it is the port enable. Index 1 holds interrupt flags, index 2 the interrupt mask, index 3 the pad output value, index 4 the pad direction (1 = drive). Indices 5 to 7 are general storage.
- R7: Reading an address from 8 to 255 returns 0x00. Writing to such an address changes no register.
- R8: `int_req_n` is low exactly when (flags AND mask) is nonzero.
- R9: While control bit 0 is 0, host accesses have no effect, `pad_oe` equals the direction register and `pad_out` equals the pad output register. Only a reset leaves this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low access select |
| wr_sel | input | 1 | 1 = host writes, 0 = host reads |
| dsel | input | 1 | 1 = register data, 0 = address register |
| pad_in | input | 8 | Bus value from the pads |
| pad_out | output | 8 | Value driven onto the pads |
| pad_oe | output | 8 | Per-bit pad drive enable |
| int_req_n | output | 1 | Active-low interrupt request |

## Verification
A write commit can land in the same cycle in which the next access has already pulled the select low. This happens because the commit waits in the synchronizer for three edges after deselect. The bench provokes this overlap with random gaps of one cycle between accesses, and it drives random values on the bus and control lines as soon as each access ends. Each read is sampled late in its select window and compared with a model. Any write that used a stale or post-deselect bus value, or any write the port missed, shows up as a mismatch.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int HRP_DW    = 8;
  localparam int HRP_AW    = 8;
  localparam int HRP_NREGS = 8;

  localparam int IDX_CTRL  = 0;
  localparam int IDX_IFLAG = 1;
  localparam int IDX_IMASK = 2;
  localparam int IDX_GOUT  = 3;
  localparam int IDX_GDIR  = 4;

  localparam logic [7:0] CTRL_RST = 8'h01;

  function automatic logic [7:0] reg_reset(input int idx);
    return (idx == IDX_CTRL) ? CTRL_RST : 8'h00;
  endfunction
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hrp_access.sv
module hrp_access #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_sel,
  input  logic          dsel,
  input  logic [DW-1:0] pad_in,
  input  logic          en,
  output logic [AW-1:0] addr_q,
  output logic          wr_en,
  output logic [DW-1:0] wr_data
);
  localparam int SW = DW + 3;

  logic [SW-1:0] s_q;
  logic          s_cs_n, s_wr, s_dsel;
  logic [DW-1:0] s_bus;

  hrp_sync #(.W(SW), .STAGES(2), .RST_VAL({1'b1, {(SW-1){1'b0}}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, wr_sel, dsel, pad_in}), .q(s_q)
  );

  assign s_cs_n = s_q[SW-1];
  assign s_wr   = s_q[SW-2];
  assign s_dsel = s_q[SW-3];
  assign s_bus  = s_q[DW-1:0];

  logic          cs_d_q, cs_d_d;
  logic          hold_wr_q, hold_wr_d;
  logic          hold_ds_q, hold_ds_d;
  logic [DW-1:0] hold_bus_q, hold_bus_d;
  logic [AW-1:0] addr_d;
  logic          commit, addr_ld;

  always_comb begin
    cs_d_d     = s_cs_n;
    hold_wr_d  = hold_wr_q;
    hold_ds_d  = hold_ds_q;
    hold_bus_d = hold_bus_q;
    if (!s_cs_n) begin
      hold_wr_d  = s_wr;
      hold_ds_d  = s_dsel;
      hold_bus_d = s_bus;
    end
    commit  = s_cs_n && !cs_d_q && hold_wr_q && en;
    addr_ld = commit && !hold_ds_q;
    addr_d  = addr_ld ? hold_bus_q[AW-1:0] : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q     <= 1'b1;
      hold_wr_q  <= 1'b0;
      hold_ds_q  <= 1'b0;
      hold_bus_q <= '0;
      addr_q     <= '0;
    end else begin
      cs_d_q     <= cs_d_d;
      hold_wr_q  <= hold_wr_d;
      hold_ds_q  <= hold_ds_d;
      hold_bus_q <= hold_bus_d;
      addr_q     <= addr_d;
    end
  end

  assign wr_en   = commit && hold_ds_q;
  assign wr_data = hold_bus_q;

  // R2: a committed write follows a deselect seen at the pins
  a_r2_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (commit) |-> $past(cs_n, 2));

  // R2: one commit per access
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit) |=> !commit);

  // R3: the address register moves only at a commit of an address write
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit) |=> $stable(addr_q));
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
  import hrp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NREGS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          port_en,
  output logic [DW-1:0] irq_flags,
  output logic [DW-1:0] irq_mask,
  output logic [DW-1:0] gpio_out,
  output logic [DW-1:0] gpio_dir
);
  localparam int FW = NREGS * DW;

  logic [FW-1:0] regs_flat;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] q, d;
    logic          hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_comb d = hit ? wr_data : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DW'(reg_reset(g));
      else        q <= d;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs_flat[i*DW +: DW];
    end
  end

  assign port_en   = regs_flat[IDX_CTRL*DW];
  assign irq_flags = regs_flat[IDX_IFLAG*DW +: DW];
  assign irq_mask  = regs_flat[IDX_IMASK*DW +: DW];
  assign gpio_out  = regs_flat[IDX_GOUT*DW +: DW];
  assign gpio_dir  = regs_flat[IDX_GDIR*DW +: DW];

  // R7: a write beyond the implemented range leaves every register alone
  a_r7_no_wild_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= AW'(NREGS))) |=> $stable(regs_flat));
endmodule

// File: rtl/hrp_pinmux.sv
module hrp_pinmux #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          en,
  input  logic          cs_n,
  input  logic          wr_sel,
  input  logic          dsel,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] gpio_out,
  input  logic [DW-1:0] gpio_dir,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe
);
  logic host_rd;

  always_comb begin
    host_rd = !cs_n && !wr_sel;
    if (en) begin
      pad_oe  = {DW{host_rd}};
      pad_out = dsel ? rd_data : DW'(addr_q);
    end else begin
      pad_oe  = gpio_dir;
      pad_out = gpio_out;
    end
  end
endmodule

// File: rtl/hrp_top.sv
module hrp_top
  import hrp_pkg::*;
#(
  parameter int DW = HRP_DW,
  parameter int AW = HRP_AW,
  parameter int NREGS = HRP_NREGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_sel,
  input  logic          dsel,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  output logic          int_req_n
);
  logic          rst_s;
  logic [AW-1:0] addr_q;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          port_en;
  logic [DW-1:0] irq_flags, irq_mask, gpio_out, gpio_dir;

  hrp_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s)
  );

  hrp_access #(.DW(DW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .wr_sel(wr_sel), .dsel(dsel),
    .pad_in(pad_in), .en(port_en), .addr_q(addr_q), .wr_en(wr_en),
    .wr_data(wr_data)
  );

  hrp_regfile #(.DW(DW), .AW(AW), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(addr_q),
    .wr_data(wr_data), .rd_addr(addr_q), .rd_data(rd_data),
    .port_en(port_en), .irq_flags(irq_flags), .irq_mask(irq_mask),
    .gpio_out(gpio_out), .gpio_dir(gpio_dir)
  );

  hrp_pinmux #(.DW(DW), .AW(AW)) u_pin (
    .en(port_en), .cs_n(cs_n), .wr_sel(wr_sel), .dsel(dsel),
    .addr_q(addr_q), .rd_data(rd_data), .gpio_out(gpio_out),
    .gpio_dir(gpio_dir), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign int_req_n = ~|(irq_flags & irq_mask);

  // R8: the request line only moves after a register write
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (!wr_en) |=> $stable(int_req_n));

  // R9: no register write while the port is disabled
  a_r9_locked: assert property (@(posedge clk) disable iff (!rst_s)
    (!port_en) |-> !wr_en);

  // R5: pads float outside a host read while enabled
  a_r5_float: assert property (@(posedge clk) disable iff (!rst_s)
    (port_en && (cs_n || wr_sel)) |-> (pad_oe == '0));
endmodule

// File: tb/sim_hrp_top.sv
module sim_hrp_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr_sel = 1'b0;
  logic       dsel = 1'b0;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic       int_req_n;

  always #(CLK_P/2) clk = ~clk;

  hrp_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_sel(wr_sel), .dsel(dsel),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .int_req_n(int_req_n)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] m_addr;
  logic [7:0] m_reg [8];
  bit   m_en;

  function automatic logic [7:0] exp_read(bit d);
    if (!d) return m_addr;
    if (m_addr < 8) return m_reg[m_addr[2:0]];
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return ~|(m_reg[1] & m_reg[2]);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic acc(bit wr, bit d, logic [7:0] v, int gap, output logic [7:0] rd);
    logic [7:0] e;
    @(negedge clk);
    e = exp_read(d);
    cs_n = 1'b0; wr_sel = wr; dsel = d; pad_in = v;
    repeat (3) @(negedge clk);
    rd = pad_out;
    if (m_en) begin
      if (!wr) begin
        chk("R5 read drive", pad_oe, 8'hFF);
        if (d && m_addr >= 8) chk("R7 unimplemented read", pad_out, e);
        else if (d) chk("R4/R3 data read", pad_out, e);
        else chk("R4/R3 address read", pad_out, e);
      end else begin
        chk("R5 write no drive", pad_oe, 8'h00);
      end
    end else begin
      chk("R9 pins follow direction", pad_oe, m_reg[4]);
      chk("R9 pins follow output", pad_out, m_reg[3]);
    end
    cs_n = 1'b1;
    pad_in = 8'($urandom); wr_sel = 1'($urandom); dsel = 1'($urandom);
    #1;
    if (m_en) chk("R5 idle no drive", pad_oe, 8'h00);
    if (wr && m_en) begin
      if (!d) m_addr = v;
      else if (m_addr < 8) m_reg[m_addr[2:0]] = v;
    end
    if (gap >= 3) begin
      repeat (3) @(negedge clk);
      chk("R8 irq level", {7'd0, int_req_n}, {7'd0, exp_irq()});
      repeat (gap - 3) @(negedge clk);
    end else begin
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] v);
    logic [7:0] rd;
    acc(1'b1, 1'b0, a, 3, rd);
    acc(1'b1, 1'b1, v, 3, rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 01 expected 00");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd1357));
    m_addr = 8'h00; m_en = 1'b1;
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    m_reg[0] = 8'h01;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq high", {7'd0, int_req_n}, 8'h01);
    chk("R1 pads float", pad_oe, 8'h00);
    acc(1'b0, 1'b0, 8'h00, 1, rd);
    chk("R1 address zero", rd, 8'h00);
    acc(1'b0, 1'b1, 8'h00, 1, rd);
    chk("R1 control reset", rd, 8'h01);
    for (int i = 1; i < 8; i++) begin
      wr_reg_addr_only: begin
        acc(1'b1, 1'b0, 8'(i), 2, rd);
        acc(1'b0, 1'b1, 8'h00, 1, rd);
        chk("R1 register reset", rd, 8'h00);
      end
    end

    // R6 R8 interrupt from flags and mask
    wr_reg(8'd1, 8'h0C);
    wr_reg(8'd2, 8'h04);
    chk("R8 irq asserted", {7'd0, int_req_n}, 8'h00);
    wr_reg(8'd2, 8'h03);
    chk("R8 irq masked", {7'd0, int_req_n}, 8'h01);

    // R2 commit latency: third rising edge after deselect
    acc(1'b1, 1'b0, 8'd2, 3, rd);
    @(negedge clk);
    cs_n = 1'b0; wr_sel = 1'b1; dsel = 1'b1; pad_in = 8'h08;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; pad_in = 8'h00; dsel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 not yet committed", {7'd0, int_req_n}, 8'h01);
    @(negedge clk);
    chk("R2 committed on third edge", {7'd0, int_req_n}, 8'h00);
    m_reg[2] = 8'h08;

    // R7 out-of-range write is ignored, read gives zero
    wr_reg(8'h80, 8'h55);
    acc(1'b0, 1'b1, 8'h00, 1, rd);
    chk("R7 read zero", rd, 8'h00);
    for (int i = 0; i < 8; i++) begin
      acc(1'b1, 1'b0, 8'(i), 1, rd);
      acc(1'b0, 1'b1, 8'h00, 1, rd);
      chk("R7 registers untouched", rd, m_reg[i]);
    end

    // random traffic with short gaps (R2 R3 R4 R6)
    for (int n = 0; n < 400; n++) begin
      bit w, d;
      logic [7:0] v;
      int gap;
      w = 1'($urandom); d = 1'($urandom);
      gap = 1 + int'($urandom % 4);
      if (!d) v = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 10);
      else v = 8'($urandom);
      if (w && d && m_addr == 8'h00) v = v | 8'h01;
      acc(w, d, v, gap, rd);
    end

    // R9 disable: pads become general purpose, accesses ignored
    wr_reg(8'd3, 8'h3C);
    wr_reg(8'd4, 8'hA5);
    wr_reg(8'd0, 8'h00);
    m_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 direction on pads", pad_oe, 8'hA5);
    chk("R9 value on pads", pad_out, 8'h3C);
    acc(1'b1, 1'b1, 8'h01, 4, rd);
    acc(1'b1, 1'b0, 8'd3, 4, rd);
    acc(1'b1, 1'b1, 8'hFF, 4, rd);
    acc(1'b0, 1'b1, 8'h00, 4, rd);
    chk("R9 still disabled oe", pad_oe, 8'hA5);
    chk("R9 output unchanged", pad_out, 8'h3C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule